// File: doc/BRIEF.md
# Guarded Power-of-Two System Clock Prescaler

This block slows the system clock of a chip by a power-of-two factor chosen at run time. It runs entirely on the undivided master clock. It produces a one-cycle enable pulse, once per divided period, which downstream clock gating or synchronous logic uses as the system clock edge. A 4-bit select code sets the factor. Codes 0 to 8 give factors 1 to 256, and the unused codes fall back to 256.

Software reaches the select through an 8-bit control register, and a timed two-step unlock protects it. A first write of exactly 0x80 opens a short window. A second write, which must land within that window and must have bit 7 clear, loads the new select and closes the window. The window also closes by itself after four master cycles.

The divider never changes its rate in the middle of a period. A new select is adopted only when the current period ends. Every interval between enable pulses is therefore a whole old period or a whole new period, and never a shortened one. A strap input picks the factor used out of reset, either divide by 1 or divide by 8.

Top module: `sysclk_prescaler`

## Requirements
- R1: The read-back byte holds the unlock flag at bit 7, zeros at bits 6..4 and the current select code at bits 3..0.
- R2: When reset is sampled low at a clock edge, the unlock flag clears and the divider counter restarts. The select takes 0000 if the strap is low and 0011 if the strap is high.
- R3: The unlock flag sets only from a write of exactly 0x80 while the flag is clear. Every other write pattern leaves the flag unchanged.
- R4: After an arming write in cycle c, the flag reads 1 in cycles c+1 through c+4 and reads 0 from cycle c+5.
- R5: Writing 0x80 again while the flag is set neither clears the flag nor extends its four-cycle window.
- R6: A write with bit 7 clear loads bits 3..0 into the select only while the flag is set, and the flag reads 0 in the next cycle. While the flag is clear, such a write has no effect.
- R7: Select code k, for k from 0 to 8, gives a period of 2^k master cycles. Codes 9 to 15 give 256 master cycles.
- R8: The enable output is high for one master cycle once per period. After reset is released, the first pulse comes in the N-th cycle, where N is the period.
- R9: A changed select is adopted at the end of the first enable pulse seen after the write has landed. The period in progress completes at the old length, and every later period has the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Undivided master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_slow | input | 1 | Strap that picks divide by 8 (high) or divide by 1 (low) out of reset |
| wr_en | input | 1 | Register write strobe, one write per cycle it is high |
| wr_data | input | 8 | Write data for the control register |
| rd_data | output | 8 | Control register read-back |
| div_en | output | 1 | One-cycle pulse that marks each divided clock edge |

## Verification
The bench attacks the unlock window at both of its edges. It writes the select in the fourth cycle after arming and again in the fifth. A window that is off by one would accept the late write or reject the legal one. It re-arms in the middle of the window, where a design that restarts its timer would keep the flag up past cycle c+4. It also sends near-miss patterns such as 0x81 or 0xC0, which a loose decoder would treat as the key.

Select changes are timed against every phase of a long period and switch between the 256 and 2 extremes. A divider that reloads at once would produce a shortened interval, and one that waits an extra period would hold the old rate for too long. Codes above 8 confirm the clamp to 256, where a careless shift would wrap to a small factor.

// File: rtl/psc_pkg.sv
// Shared sizing and helpers for the prescaler.
// Assumes power-of-two division with codes above MAX_CODE clamped.
package psc_pkg;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 4;
    localparam int MAX_CODE = 8;
    localparam int CNT_W    = MAX_CODE;
    localparam int N_CODES  = 1 << SEL_W;

    // Terminal count (period minus one) for a select code.
    function automatic logic [CNT_W-1:0] code_limit(input int code);
        if (code >= MAX_CODE) return {CNT_W{1'b1}};
        return CNT_W'((64'd1 << code) - 64'd1);
    endfunction
endpackage

// File: rtl/psc_unlock_reg.sv
// Control register with a timed unlock.
// Writing KEY arms a window of WIN cycles. A write with the top bit clear,
// made inside the window, loads the select and closes the window.
// Assumes at most one write per cycle and that software keeps interrupts away.
module psc_unlock_reg #(
    parameter int DW       = 8,
    parameter int SW       = 4,
    parameter int WIN      = 4,
    parameter int RST_FAST = 0,
    parameter int RST_SLOW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_slow,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          arm,
    output logic [SW-1:0] sel
);
    localparam int TMR_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [DW-1:0] KEY = {1'b1, {(DW-1){1'b0}}};

    logic [TMR_W-1:0] tmr;
    logic             is_key;
    logic             sel_wr;

    // Decode the arming pattern and a select load.
    always_comb begin
        is_key = wr_en && (wr_data == KEY);
        sel_wr = wr_en && arm && !wr_data[DW-1];
    end

    // Unlock flag, window timer and select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm <= 1'b0;
            tmr <= '0;
            sel <= boot_slow ? SW'(RST_SLOW) : SW'(RST_FAST);
        end else if (sel_wr) begin
            sel <= wr_data[SW-1:0];
            arm <= 1'b0;
        end else if (is_key && !arm) begin
            arm <= 1'b1;
            tmr <= TMR_W'(WIN - 1);
        end else if (arm) begin
            if (tmr == '0) arm <= 1'b0;
            else           tmr <= tmr - 1'b1;
        end
    end

    // Checker: counts the cycles the flag has been up.
    logic [TMR_W:0] arm_age;
    always_ff @(posedge clk) begin
        if (!rst_n)   arm_age <= '0;
        else if (arm) arm_age <= arm_age + 1'b1;
        else          arm_age <= '0;
    end

    // R3
    arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm) |-> ($past(wr_en) && $past(wr_data) == KEY));
    // R4
    arm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (arm_age < (TMR_W+1)'(WIN)));
    // R6
    sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel) |-> ($past(arm) && $past(wr_en) && !$past(wr_data[DW-1])));
    // R6
    sel_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel) |-> !arm);
endmodule

// File: rtl/psc_divider.sv
// Power-of-two divider on the master clock. Emits a one-cycle enable at the
// end of each period. The select is only taken over at a period boundary, so
// every interval is either a whole old period or a whole new one.
// Assumes sel_req is synchronous to clk.
module psc_divider
    import psc_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel_req,
    input  logic [SW-1:0] sel_init,
    output logic          div_en
);
    localparam int NC = 1 << SW;

    logic [CW-1:0] lim_tab [NC];
    logic [SW-1:0] act;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Terminal count for each select code.
    for (genvar k = 0; k < NC; k++) begin : g_lim
        assign lim_tab[k] = CW'(code_limit(k));
    end

    // Current terminal count and period-end pulse.
    always_comb begin
        lim    = lim_tab[act];
        div_en = (cnt == lim);
    end

    // Period counter and active select, which is swapped only at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            act <= sel_init;
        end else if (div_en) begin
            cnt <= '0;
            act <= sel_req;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9
    act_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> $past(div_en));
    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);
endmodule

// File: rtl/sysclk_prescaler.sv
// Top of the prescaler: an unlock-protected control register feeding a
// boundary-synchronised power-of-two divider.
// Assumes one clock domain and a synchronous active-low reset.
module sysclk_prescaler
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_slow,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              div_en
);
    localparam int RSV_W    = DATA_W - 1 - SEL_W;
    localparam int SEL_SLOW = 3;

    logic             arm;
    logic [SEL_W-1:0] sel;
    logic [SEL_W-1:0] sel_init;

    // Reset select chosen by the strap.
    always_comb sel_init = boot_slow ? SEL_W'(SEL_SLOW) : '0;

    psc_unlock_reg #(
        .DW(DATA_W), .SW(SEL_W), .WIN(4), .RST_FAST(0), .RST_SLOW(SEL_SLOW)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .boot_slow(boot_slow),
        .wr_en(wr_en), .wr_data(wr_data), .arm(arm), .sel(sel)
    );

    psc_divider #(.SW(SEL_W), .CW(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .sel_req(sel), .sel_init(sel_init),
        .div_en(div_en)
    );

    // Read-back layout: flag, reserved zeros, select.
    always_comb rd_data = {arm, {RSV_W{1'b0}}, sel};
endmodule

// File: tb/tb_sysclk_prescaler.sv
module tb_sysclk_prescaler;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_slow = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       div_en;

    logic want_rst = 1'b1;
    logic want_strap = 1'b0;

    int checks = 0;
    int errors = 0;

    // Reference state, built from the requirements.
    logic       m_valid = 1'b0;
    logic       m_arm;
    int         m_tmr;
    logic [3:0] m_sel;
    int         m_cnt;
    logic [3:0] m_act;

    sysclk_prescaler dut (
        .clk(clk), .rst_n(rst_n), .boot_slow(boot_slow),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .div_en(div_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_of(logic [3:0] c);
        return (c >= 4'd8) ? 256 : (1 << c);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One master cycle: check at the falling edge, drive, advance the model.
    task automatic step(logic we, logic [7:0] d);
        int n_tmr, n_cnt;
        logic n_arm;
        logic [3:0] n_sel, n_act;
        @(negedge clk);
        if (m_valid && rst_n) begin
            chk(rd_data == {m_arm, 3'b000, m_sel}, "R1 R3 R4 R5 R6 readback",
                int'(rd_data), int'({m_arm, 3'b000, m_sel}));
            chk(div_en == (m_cnt == period_of(m_act) - 1), "R7 R8 R9 enable",
                int'(div_en), int'(m_cnt == period_of(m_act) - 1));
        end
        rst_n = want_rst;
        boot_slow = want_strap;
        wr_en = we;
        wr_data = d;
        if (!want_rst) begin
            n_arm = 1'b0; n_tmr = 0;
            n_sel = want_strap ? 4'd3 : 4'd0;
            n_cnt = 0; n_act = n_sel;
        end else begin
            n_arm = m_arm; n_tmr = m_tmr; n_sel = m_sel;
            if (m_cnt == period_of(m_act) - 1) begin
                n_cnt = 0; n_act = m_sel;
            end else begin
                n_cnt = m_cnt + 1; n_act = m_act;
            end
            if (we && m_arm && !d[7]) begin
                n_sel = d[3:0]; n_arm = 1'b0;
            end else if (we && d == 8'h80 && !m_arm) begin
                n_arm = 1'b1; n_tmr = 3;
            end else if (m_arm) begin
                if (m_tmr == 0) n_arm = 1'b0;
                else n_tmr = m_tmr - 1;
            end
        end
        @(posedge clk);
        m_arm = n_arm; m_tmr = n_tmr; m_sel = n_sel;
        m_cnt = n_cnt; m_act = n_act;
        if (!want_rst) m_valid = 1'b1;
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00);
    endtask

    task automatic do_reset(logic s);
        want_rst = 1'b0;
        want_strap = s;
        idle(3);
        want_rst = 1'b1;
    endtask

    // Cycles between two successive enable pulses, seen just after edges.
    task automatic measure(output int len);
        int guard;
        guard = 0;
        while (!div_en && guard < 600) begin idle(1); guard++; end
        len = 0;
        idle(1);
        len = 1;
        while (!div_en && len < 600) begin idle(1); len++; end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int len;
        int first;

        // R2: strap low gives select 0000 and a pulse every cycle
        do_reset(1'b0);
        chk(rd_data == 8'h00, "R2 reset strap low", rd_data, 8'h00);
        chk(div_en == 1'b1, "R8 first pulse at divide by 1", div_en, 1);

        // R2: strap high gives select 0011, first pulse in the eighth cycle
        do_reset(1'b1);
        chk(rd_data == 8'h03, "R2 reset strap high", rd_data, 8'h03);
        first = 1;
        while (!div_en && first < 20) begin idle(1); first++; end
        chk(first == 8, "R8 first pulse position", first, 8);

        // R3: near-miss keys do not arm
        step(1'b1, 8'h81); chk(rd_data[7] == 1'b0, "R3 0x81 ignored", rd_data[7], 0);
        step(1'b1, 8'hC0); chk(rd_data[7] == 1'b0, "R3 0xC0 ignored", rd_data[7], 0);
        // R6: select write without the flag is ignored
        step(1'b1, 8'h01); chk(rd_data == 8'h03, "R6 unarmed write", rd_data, 8'h03);

        // R4 and R5: re-arm mid-window, flag drops at c+5
        step(1'b1, 8'h80);
        chk(rd_data[7] == 1'b1, "R4 armed at c+1", rd_data[7], 1);
        step(1'b0, 8'h00);
        step(1'b1, 8'h80);
        chk(rd_data[7] == 1'b1, "R5 re-arm keeps flag", rd_data[7], 1);
        step(1'b0, 8'h00);
        chk(rd_data[7] == 1'b1, "R4 still armed at c+4", rd_data[7], 1);
        step(1'b0, 8'h00);
        chk(rd_data[7] == 1'b0, "R5 window not extended", rd_data[7], 0);

        // R6: write in the fifth cycle is rejected
        step(1'b1, 8'h80); idle(4);
        step(1'b1, 8'h05);
        chk(rd_data == 8'h03, "R6 late write rejected", rd_data, 8'h03);

        // R6: write in the fourth cycle is accepted, flag closes
        step(1'b1, 8'h80); idle(3);
        step(1'b1, 8'h0B);
        chk(rd_data == 8'h0B, "R6 write at c+4 accepted", rd_data, 8'h0B);

        // R7 and R9: reserved code runs at 256
        measure(len);
        measure(len);
        chk(len == 256, "R7 code 11 period", len, 256);

        // R9: change from 256 to 2 in mid-period
        idle(100);
        step(1'b1, 8'h80);
        step(1'b1, 8'h01);
        measure(len);
        chk(len == 2, "R9 new period after boundary", len, 2);

        // R7: code 8 gives 256
        step(1'b1, 8'h80); step(1'b1, 8'h08);
        measure(len); measure(len);
        chk(len == 256, "R7 code 8 period", len, 256);

        // Random phase: arm and write with random gaps, noise writes, idles
        void'($urandom(32'd1234));
        for (int r = 0; r < 4; r++) begin
            do_reset(1'($urandom_range(0, 1)));
            for (int op = 0; op < 30; op++) begin
                case ($urandom_range(0, 3))
                    0: begin
                        step(1'b1, 8'h80);
                        idle($urandom_range(0, 5));
                        step(1'b1, {1'($urandom_range(0, 7) == 0), 3'($urandom),
                                    4'($urandom_range(0, 15))});
                    end
                    1: step(1'b1, 8'($urandom));
                    2: idle($urandom_range(1, 40));
                    default: idle($urandom_range(1, 300));
                endcase
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule